// File: doc/BRIEF.md
# Time-Slot Transparent Serial Receiver

This block turns a serial receive line into bytes with no framing of any kind. It does not search for flags, check a CRC or remove stuffed bits. Every bit the block accepts is shifted in least significant bit first. The most recent complete byte is always readable on a holding output. When FIFO loading is enabled, each completed byte is also written into a small receive FIFO. The FIFO has a show-ahead read port.

Byte alignment comes from outside the bit stream, in one of two ways.

- **Strobe mode:** a bit is accepted on every bit-clock enable while the strobe input is high. Each rising edge of the strobe begins a new byte.
- **Time-slot mode:** the same input carries a frame sync pulse. Counting bits from that pulse, a programmed offset and a programmed length in bytes select the bits that are accepted.

In both modes each window starts on a byte boundary and carries whole bytes.

Top module: `slot_rx`

## Requirements
- R1: After reset the holding output is 0x00, the FIFO is empty (`rd_valid` low) and `overflow` is low.
- R2: In strobe mode a bit is taken only in a cycle where `bit_en` and `sync_in` are both high. Bits are assembled LSB first (the first bit taken lands in bit 0). `hold_byte` shows the byte one cycle after its eighth bit is taken, and does not change otherwise.
- R3: In strobe mode, a bit taken while the strobe was low at the previous enabled bit clock starts a new byte. Any partial byte collected before it is discarded.
- R4: In time-slot mode the enabled bit clock on which `sync_in` is high is bit position 0. Positions `cfg_slot_ofs` through `cfg_slot_ofs + 8*cfg_slot_len - 1` are taken, and a new byte starts at position `cfg_slot_ofs`. A length of 0 takes nothing.
- R5: Bits outside the window leave `hold_byte` and the FIFO unchanged. This covers strobe low in strobe mode, and positions outside the slot in time-slot mode.
- R6: A slot of N bytes delivers N consecutive bytes, in order.
- R7: With `cfg_fifo_en` low, completed bytes update `hold_byte` but are never written into the FIFO.
- R8: With `cfg_fifo_en` high, completed bytes enter the FIFO in order. `rd_data` shows the oldest entry while `rd_valid` is high, and a cycle with `rd_en` high removes it.
- R9: A byte completing while the FIFO holds DEPTH entries is dropped, and the bytes already stored are kept. `overflow` then goes high and stays high until reset.
- R10: In time-slot mode no bit is taken until a frame sync has been seen since entering that mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit clock enable; one serial bit per high cycle |
| rx_bit | input | 1 | Serial receive data |
| sync_in | input | 1 | Receive strobe (strobe mode) or frame sync (time-slot mode) |
| cfg_slot_mode | input | 1 | 0 = strobe mode, 1 = time-slot mode |
| cfg_slot_ofs | input | OFS_W | Slot start, in bit clocks after the frame sync |
| cfg_slot_len | input | LEN_W | Slot length in bytes |
| cfg_fifo_en | input | 1 | Write completed bytes into the FIFO |
| hold_byte | output | 8 | Last completed byte |
| rd_en | input | 1 | Pop the FIFO head |
| rd_data | output | 8 | FIFO head (show-ahead) |
| rd_valid | output | 1 | FIFO not empty |
| overflow | output | 1 | Sticky: a byte was dropped on a full FIFO |

## Verification
The hardest case to reach from the ports is a byte completing against a full FIFO. The bench's read monitor normally drains bytes as they arrive, so the FIFO never fills. To reach the case, the stimulus switches the monitor off, sends more strobe-mode bytes than the FIFO can hold, and then drains it. The drain must return exactly the first DEPTH bytes, and the overflow flag must stay set.

Alignment restart is also exercised at the ports. The bench sends a partial byte, drops the strobe for one bit clock, raises it again, and expects only the later byte. Time-slot frames surround the window with random bits to show that those bits are ignored.

// File: rtl/slot_rx_pkg.sv
`timescale 1ns/1ps
package slot_rx_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef enum logic {MODE_STROBE = 1'b0, MODE_SLOT = 1'b1} rx_mode_e;
endpackage

// File: rtl/slot_rx_window.sv
`timescale 1ns/1ps
module slot_rx_window
  import slot_rx_pkg::*;
#(
  parameter int OFS_W = 8,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             sync_in,
  input  rx_mode_e         mode,
  input  logic [OFS_W-1:0] slot_ofs,
  input  logic [LEN_W-1:0] slot_len,
  output logic             take,
  output logic             win_start
);
  localparam int POS_W = OFS_W + LEN_W + 4;
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] cur_pos;
  logic             seen_q;
  logic             strobe_q;

  function automatic logic [POS_W-1:0] sat_inc(input logic [POS_W-1:0] p);
    return (p == POS_MAX) ? p : p + 1'b1;
  endfunction

  function automatic logic in_slot(input logic [POS_W-1:0] p,
                                   input logic [OFS_W-1:0] o,
                                   input logic [LEN_W-1:0] n);
    logic [POS_W-1:0] lo;
    logic [POS_W-1:0] hi;
    lo = POS_W'(o);
    hi = lo + (POS_W'(n) << 3);
    return (p >= lo) && (p < hi);
  endfunction

  assign cur_pos = sync_in ? '0 : pos_q;

  always_comb begin
    if (mode == MODE_SLOT) begin
      take      = bit_en && (seen_q || sync_in) && in_slot(cur_pos, slot_ofs, slot_len);
      win_start = take && (cur_pos == POS_W'(slot_ofs));
    end else begin
      take      = bit_en && sync_in;
      win_start = take && !strobe_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q    <= '0;
      seen_q   <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      if (mode != MODE_SLOT) seen_q <= 1'b0;
      if (bit_en) begin
        strobe_q <= (mode == MODE_STROBE) && sync_in;
        pos_q    <= sync_in ? POS_W'(1) : sat_inc(pos_q);
        if (mode == MODE_SLOT && sync_in) seen_q <= 1'b1;
      end
    end
  end

  a_r10_no_take_before_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SLOT && !seen_q && !sync_in) |-> !take);
  a_r2_take_needs_bit_clock: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> bit_en);
endmodule

// File: rtl/slot_rx_shift.sv
`timescale 1ns/1ps
module slot_rx_shift
  import slot_rx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  take,
  input  logic  win_start,
  input  logic  rx_bit,
  output byte_t hold,
  output logic  byte_done,
  output byte_t done_byte
);
  byte_t      sh_q;
  logic [2:0] cnt_q;
  logic [2:0] cnt_now;

  function automatic byte_t shift_in(input byte_t s, input logic b);
    return {b, s[BYTE_W-1:1]};
  endfunction

  assign cnt_now   = win_start ? 3'd0 : cnt_q;
  assign byte_done = take && (cnt_now == 3'd7);
  assign done_byte = shift_in(sh_q, rx_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      hold  <= '0;
    end else if (take) begin
      sh_q  <= done_byte;
      cnt_q <= cnt_now + 3'd1;
      if (byte_done) hold <= done_byte;
    end
  end

  a_r2_hold_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_done |=> $stable(hold));
  a_r3_restart_count: assert property (@(posedge clk) disable iff (!rst_n)
    (take && win_start) |=> (cnt_q == 3'd1));
endmodule

// File: rtl/slot_rx_fifo.sv
`timescale 1ns/1ps
module slot_rx_fifo
  import slot_rx_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push_req,
  input  byte_t push_data,
  input  logic  pop,
  output byte_t head,
  output logic  not_empty,
  output logic  ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  byte_t         mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          full, do_wr, do_rd;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (count == FULL_CNT);
  assign not_empty = (count != '0);
  assign do_wr     = push_req && !full;
  assign do_rd     = pop && not_empty;
  assign head      = mem[rptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      ovf   <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (do_wr) begin
        mem[wptr] <= push_data;
        wptr      <= wrap_inc(wptr);
      end
      if (do_rd) rptr <= wrap_inc(rptr);
      if (push_req && full) ovf <= 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  a_r9_full_drop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_req && !pop) |=> (count == FULL_CNT));
  a_r8_idle_level_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_req && !pop) |=> $stable(count));
  a_r8_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
endmodule

// File: rtl/slot_rx.sv
`timescale 1ns/1ps
module slot_rx
  import slot_rx_pkg::*;
#(
  parameter int OFS_W = 8,
  parameter int LEN_W = 4,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             rx_bit,
  input  logic             sync_in,
  input  logic             cfg_slot_mode,
  input  logic [OFS_W-1:0] cfg_slot_ofs,
  input  logic [LEN_W-1:0] cfg_slot_len,
  input  logic             cfg_fifo_en,
  output logic [7:0]       hold_byte,
  input  logic             rd_en,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             overflow
);
  logic     take, win_start, byte_done, push_req;
  byte_t    done_byte, hold_w, head_w;
  rx_mode_e mode;

  assign mode = rx_mode_e'(cfg_slot_mode);

  slot_rx_window #(.OFS_W(OFS_W), .LEN_W(LEN_W)) u_win (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sync_in(sync_in),
    .mode(mode), .slot_ofs(cfg_slot_ofs), .slot_len(cfg_slot_len),
    .take(take), .win_start(win_start));

  slot_rx_shift u_shift (
    .clk(clk), .rst_n(rst_n), .take(take), .win_start(win_start),
    .rx_bit(rx_bit), .hold(hold_w), .byte_done(byte_done),
    .done_byte(done_byte));

  assign push_req = byte_done && cfg_fifo_en;

  slot_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .push_data(done_byte),
    .pop(rd_en), .head(head_w), .not_empty(rd_valid), .ovf(overflow));

  assign hold_byte = hold_w;
  assign rd_data   = head_w;

  a_r7_no_fill_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_fifo_en && !rd_valid) |=> !rd_valid);
endmodule

// File: tb/tb_slot_rx.sv
`timescale 1ns/1ps
module tb_slot_rx;
  localparam int OFS_W = 8;
  localparam int LEN_W = 4;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, rx_bit = 1'b0, sync_in = 1'b0;
  logic cfg_slot_mode = 1'b0, cfg_fifo_en = 1'b0, rd_en = 1'b0;
  logic [OFS_W-1:0] cfg_slot_ofs = '0;
  logic [LEN_W-1:0] cfg_slot_len = '0;
  logic [7:0] hold_byte, rd_data;
  logic rd_valid, overflow;

  int checks = 0;
  int fails = 0;
  logic mon_on = 1'b0;
  logic [7:0] exp_q[$];
  logic [7:0] hold_exp = 8'h00;

  always #5 clk = ~clk;

  slot_rx #(.OFS_W(OFS_W), .LEN_W(LEN_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .sync_in(sync_in), .cfg_slot_mode(cfg_slot_mode),
    .cfg_slot_ofs(cfg_slot_ofs), .cfg_slot_len(cfg_slot_len),
    .cfg_fifo_en(cfg_fifo_en), .hold_byte(hold_byte), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .overflow(overflow));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Monitor: pop FIFO items as they appear and compare against the scoreboard (R8)
  always @(negedge clk) begin
    if (mon_on && rst_n && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R8: unexpected FIFO item actual 0x%0h expected none", rd_data);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (rd_data !== e) begin
          fails++;
          $display("FAIL R8: FIFO item actual 0x%0h expected 0x%0h", rd_data, e);
        end
      end
      rd_en = 1'b1;
    end else begin
      rd_en = 1'b0;
    end
  end

  task automatic tick(input logic d, input logic s, input logic en);
    @(negedge clk);
    rx_bit = d; sync_in = s; bit_en = en;
  endtask

  task automatic expect_byte(input logic [7:0] b);
    hold_exp = b;
    if (cfg_fifo_en) begin
      if (exp_q.size() < DEPTH) exp_q.push_back(b);
    end
  endtask

  task automatic strobe_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) tick(b[i], 1'b1, 1'b1);
    expect_byte(b);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'($urandom), 1'b0, 1'b0);
  endtask

  task automatic chk_hold(input string req);
    @(negedge clk);
    bit_en = 1'b0; sync_in = 1'b0;
    check(req, {24'h0, hold_byte}, {24'h0, hold_exp});
  endtask

  task automatic frame(input int ofs, input int len, input logic [23:0] data, input int total);
    cfg_slot_ofs = OFS_W'(ofs);
    cfg_slot_len = LEN_W'(len);
    for (int p = 0; p < total; p++) begin
      logic inwin;
      inwin = (p >= ofs) && (p < ofs + 8 * len);
      tick(inwin ? data[p - ofs] : 1'($urandom), p == 0, 1'b1);
      if (inwin && ((p - ofs) % 8 == 7)) expect_byte(data[(p - ofs) - 7 +: 8]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 hold", {24'h0, hold_byte}, 32'h0);
    check("R1 empty", {31'h0, rd_valid}, 32'h0);
    check("R1 overflow", {31'h0, overflow}, 32'h0);
    rst_n = 1'b1;
    mon_on = 1'b1;

    // R2 / R7: strobe byte, FIFO loading off
    strobe_byte(8'h3C);
    chk_hold("R2 lsb-first byte");
    idle(3);
    check("R7 fifo untouched", {31'h0, rd_valid}, 32'h0);

    // R2: idle bit clocks interleaved with data are ignored
    for (int i = 0; i < 8; i++) begin
      tick(8'h96 >> i, 1'b1, 1'b1);
      tick(1'($urandom), 1'b1, 1'b0);
    end
    expect_byte(8'h96);
    chk_hold("R2 gated bits");

    // R5: strobe low, bits ignored
    for (int i = 0; i < 12; i++) tick(1'($urandom), 1'b0, 1'b1);
    chk_hold("R5 strobe low ignored");

    // R3: partial byte, strobe drop, realign
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b1, 1'b1);
    tick(1'b0, 1'b0, 1'b1);
    strobe_byte(8'hA5);
    chk_hold("R3 realign");

    // R8: FIFO loading, back-to-back bytes in one strobe window
    cfg_fifo_en = 1'b1;
    strobe_byte(8'h11); strobe_byte(8'h22); strobe_byte(8'h33);
    strobe_byte(8'h44); strobe_byte(8'h55); strobe_byte(8'h66);
    chk_hold("R8 last byte hold");
    idle(10);
    check("R8 scoreboard drained", exp_q.size(), 0);

    // R10: time-slot mode, no sync yet
    cfg_slot_mode = 1'b1;
    cfg_slot_ofs = 8'd0; cfg_slot_len = 4'd2;
    for (int i = 0; i < 30; i++) tick(1'($urandom), 1'b0, 1'b1);
    chk_hold("R10 no take before sync");
    idle(3);
    check("R10 fifo empty", {31'h0, rd_valid}, 32'h0);

    // R4 / R6: slots
    frame(5, 2, 24'h00_C3_5A, 30);
    chk_hold("R4 slot ofs5 len2");
    frame(0, 3, 24'h81_7E_19, 28);
    chk_hold("R6 three-byte slot");
    frame(9, 1, 24'h00_00_F0, 40);
    chk_hold("R5 bits after slot ignored");
    frame(3, 0, 24'hFF_FF_FF, 30);
    chk_hold("R4 zero length slot");
    idle(10);
    check("R6 slot bytes drained", exp_q.size(), 0);

    // R9: overflow
    cfg_slot_mode = 1'b0;
    mon_on = 1'b0;
    idle(2);
    strobe_byte(8'hD1); strobe_byte(8'hD2); strobe_byte(8'hD3);
    strobe_byte(8'hD4); strobe_byte(8'hD5); strobe_byte(8'hD6);
    chk_hold("R9 hold still updates");
    check("R9 overflow set", {31'h0, overflow}, 32'h1);
    mon_on = 1'b1;
    idle(10);
    check("R9 kept bytes drained", exp_q.size(), 0);
    check("R9 overflow sticky", {31'h0, overflow}, 32'h1);
    check("R9 fifo empty", {31'h0, rd_valid}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule